// File: doc/BRIEF.md
# Memory Error Capture Register File

This block holds the error-reporting registers of a memory controller whose store is protected by a Hamming code and a parity bit. Three 16-bit registers sit at fixed bus addresses. An address register reports where the first error happened. A status register records what the checker saw at that error. A control register sets the interrupt enables and the diagnostic settings that are sent back to the checker.

Each time the controller loads a memory address, the address is noted. The external checker reports each checked read with its syndrome, the Hamming bits read from the array, the recomputed parity result, the stored parity bit, and whether the error can be corrected. Only the first error is captured. Later errors do not disturb the captured record until software writes the status register, which also clears the pending task-wakeup request. Status and control values are low-true on the bus, so a zero bit means the condition is present or enabled.

Top module: `mem_err_regs`

## Requirements
- R1: A bus read (`bus_rd`=1) returns the address register at 16'hFE14, the status register at 16'hFE15 and the control register at 16'hFE16. A read of any other address, or with `bus_rd`=0, returns 16'h0000.
- R2: While an error is held, the address register reads the low 16 bits of the access address noted before that error. While no error is held, it reads the low 16 bits of the most recent `acc_addr` loaded with `acc_valid`.
- R3: An event with `err_valid`=1 is an error when the syndrome is non-zero or `err_perr`=1. The status register reads as the bitwise inverse of {bank[15:14], syndrome[13:8], parity bit[7], parity error[6], Hamming bits[5:0]}. The bank is bits 17:16 of the noted access address, which are bits 16:15 of its doubleword address.
- R4: An event with zero syndrome and no parity error captures nothing. Once an error is held, further errors and accesses leave the address and status registers unchanged.
- R5: Any write to 16'hFE15 releases the held error, clears the status register to read 16'hFFFF, re-arms capture and clears `wakeup`. When that write and an error arrive in the same cycle, the write wins and the error is dropped.
- R6: A write to 16'hFE16 stores the control word. The word reads back with bits 3:0 and 15 forced to one. `ecc_test_code` is the inverse of bits 10:4, `ecc_test_mode` is the inverse of bit 11, and `ecc_corr_en` equals bit 14.
- R7: An error with `err_correctable`=1 sets `wakeup` when control bit 12 is 0. An error with `err_correctable`=0 sets `wakeup` when control bit 13 is 0. The request stays set until the status register is written.
- R8: After reset the control register reads 16'hFFFF, the status register reads 16'hFFFF, the address register reads 16'h0000, `wakeup` is 0, `ecc_corr_en` is 1 and `ecc_test_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus register address |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data (combinational) |
| acc_valid | input | 1 | Memory address load |
| acc_addr | input | ADDR_W | Word address being loaded |
| err_valid | input | 1 | Checker result for a read |
| err_correctable | input | 1 | Error can be corrected (single bit) |
| err_syndrome | input | 6 | Hamming syndrome |
| err_hamming | input | 6 | Hamming bits read from memory |
| err_perr | input | 1 | Parity check failed |
| err_pbit | input | 1 | Stored parity bit |
| wakeup | output | 1 | Error task wakeup request |
| ecc_corr_en | output | 1 | Correction enabled, to the checker |
| ecc_test_mode | output | 1 | Diagnostic test mode, to the checker |
| ecc_test_code | output | 7 | Diagnostic test code, to the checker |

## Verification
On every cycle, the assertions check three things. A held record and its address stay frozen until a status write. The first real error always sets the held state. Every rising edge of `wakeup` follows an error event, and a status write always drops it. Only the bench scenarios can show the rest. These are the exact low-true bit placement of each status field, the switch of the address register between the live and the latched value, the enable-by-class decision for the wakeup, and the priority of a clear over an error that arrives in the same cycle.

// File: rtl/mesr_pkg.sv
package mesr_pkg;
  localparam int REG_W  = 16;
  localparam int SYN_W  = 6;
  localparam int BANK_W = 2;

  // Captured error record, bit positions as seen on the bus (before inversion)
  typedef struct packed {
    logic [BANK_W-1:0] bank;     // 15:14
    logic [SYN_W-1:0]  syndrome; // 13:8
    logic              pbit;     // 7
    logic              perr;     // 6
    logic [SYN_W-1:0]  hamming;  // 5:0
  } err_rec_t;

  localparam logic [REG_W-1:0] CTL_SPARE_MASK = 16'h800F;
endpackage

// File: rtl/mesr_capture.sv
module mesr_capture
  import mesr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              err_hit,
  input  logic [SYN_W-1:0]  syndrome,
  input  logic [SYN_W-1:0]  hamming,
  input  logic              perr,
  input  logic              pbit,
  input  logic              clr,
  output logic              held,
  output err_rec_t          rec,
  output logic [REG_W-1:0]  mear,
  output logic [REG_W-1:0]  live_addr
);
  localparam int HI_W = ADDR_W - REG_W;

  logic [ADDR_W-1:0] last_q, last_d;
  logic              held_q, held_d;
  err_rec_t          rec_q, rec_d;
  logic [REG_W-1:0]  mear_q, mear_d;
  logic              capture;

  assign capture = err_hit && !held_q && !clr;

  always_comb begin
    last_d = last_q;
    held_d = held_q;
    rec_d  = rec_q;
    mear_d = mear_q;
    if (acc_valid) last_d = acc_addr;
    if (clr) begin
      held_d = 1'b0;
      rec_d  = '0;
    end else if (capture) begin
      held_d        = 1'b1;
      rec_d.bank    = last_q[ADDR_W-1 -: HI_W];
      rec_d.syndrome = syndrome;
      rec_d.pbit    = pbit;
      rec_d.perr    = perr;
      rec_d.hamming = hamming;
      mear_d        = last_q[REG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      held_q <= 1'b0;
      rec_q  <= '0;
      mear_q <= '0;
    end else begin
      last_q <= last_d;
      held_q <= held_d;
      rec_q  <= rec_d;
      mear_q <= mear_d;
    end
  end

  assign held      = held_q;
  assign rec       = rec_q;
  assign mear      = mear_q;
  assign live_addr = last_q[REG_W-1:0];

  // R4: a held record stays frozen until cleared
  p_frozen_rec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !clr) |=> ($stable(rec_q) && $stable(mear_q)));
  // R2: the first real error always arms the held state
  p_first_err_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hit && !held_q && !clr) |=> held_q);
  // R5: a clear always releases the held state
  p_clear_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !held_q);
endmodule

// File: rtl/mesr_ctl.sv
module mesr_ctl
  import mesr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctl
);
  logic [REG_W-1:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr) ctl_d = wdata | CTL_SPARE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '1;
    else        ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;

  // R6: without a write the control word does not move
  p_ctl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctl_q));
endmodule

// File: rtl/mesr_wake.sv
module mesr_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic err_hit,
  input  logic correctable,
  input  logic sb_en,
  input  logic db_en,
  input  logic clr,
  output logic wakeup
);
  logic wake_q, wake_d;
  logic cause;

  assign cause = err_hit && (correctable ? sb_en : db_en);

  always_comb begin
    wake_d = wake_q;
    if (clr)        wake_d = 1'b0;
    else if (cause) wake_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  assign wakeup = wake_q;

  // R7: a wakeup only rises after an error event
  p_wake_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_q) |-> $past(err_hit));
  // R5: a status write withdraws the wakeup
  p_wake_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !wake_q);
endmodule

// File: rtl/mem_err_regs.sv
module mem_err_regs
  import mesr_pkg::*;
#(
  parameter int               ADDR_W    = 18,
  parameter logic [REG_W-1:0] ADR_MEAR  = 16'hFE14,
  parameter logic [REG_W-1:0] ADR_STAT  = 16'hFE15,
  parameter logic [REG_W-1:0] ADR_CTL   = 16'hFE16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              err_valid,
  input  logic              err_correctable,
  input  logic [5:0]        err_syndrome,
  input  logic [5:0]        err_hamming,
  input  logic              err_perr,
  input  logic              err_pbit,
  output logic              wakeup,
  output logic              ecc_corr_en,
  output logic              ecc_test_mode,
  output logic [6:0]        ecc_test_code
);
  logic             sel_mear, sel_stat, sel_ctl;
  logic             stat_wr, ctl_wr, err_hit, held;
  err_rec_t         rec;
  logic [REG_W-1:0] mear, live_addr, ctl;

  assign sel_mear = (bus_addr == ADR_MEAR);
  assign sel_stat = (bus_addr == ADR_STAT);
  assign sel_ctl  = (bus_addr == ADR_CTL);
  assign stat_wr  = bus_wr && sel_stat;
  assign ctl_wr   = bus_wr && sel_ctl;
  assign err_hit  = err_valid && ((|err_syndrome) || err_perr);

  mesr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .err_hit(err_hit), .syndrome(err_syndrome), .hamming(err_hamming),
    .perr(err_perr), .pbit(err_pbit), .clr(stat_wr), .held(held),
    .rec(rec), .mear(mear), .live_addr(live_addr)
  );

  mesr_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(bus_wdata), .ctl(ctl)
  );

  mesr_wake u_wake (
    .clk(clk), .rst_n(rst_n), .err_hit(err_hit),
    .correctable(err_correctable), .sb_en(!ctl[12]), .db_en(!ctl[13]),
    .clr(stat_wr), .wakeup(wakeup)
  );

  assign ecc_corr_en   = ctl[14];
  assign ecc_test_mode = !ctl[11];
  assign ecc_test_code = ~ctl[10:4];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_mear)      bus_rdata = held ? mear : live_addr;
      else if (sel_stat) bus_rdata = ~rec;
      else if (sel_ctl)  bus_rdata = ctl;
    end
  end

  // R1: register selects are mutually exclusive
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_mear, sel_stat, sel_ctl}));
endmodule

// File: tb/mem_err_regs_test.sv
module mem_err_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_MEAR = 16'hFE14, A_STAT = 16'hFE15, A_CTL = 16'hFE16;

  // wakeup class table: {correctable, control word, expected wakeup}
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 16'hEFFF, 1'b1},
    {1'b1, 16'hDFFF, 1'b0},
    {1'b0, 16'hDFFF, 1'b1},
    {1'b0, 16'hEFFF, 1'b0},
    {1'b1, 16'hFFFF, 1'b0},
    {1'b0, 16'hCFFF, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_rd = 0, bus_wr = 0, acc_valid = 0;
  logic [17:0] acc_addr = 0;
  logic err_valid = 0, err_correctable = 0, err_perr = 0, err_pbit = 0;
  logic [5:0] err_syndrome = 0, err_hamming = 0;
  logic wakeup, ecc_corr_en, ecc_test_mode;
  logic [6:0] ecc_test_code;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_err_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .err_valid(err_valid),
    .err_correctable(err_correctable), .err_syndrome(err_syndrome),
    .err_hamming(err_hamming), .err_perr(err_perr), .err_pbit(err_pbit),
    .wakeup(wakeup), .ecc_corr_en(ecc_corr_en), .ecc_test_mode(ecc_test_mode),
    .ecc_test_code(ecc_test_code)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic access(input logic [17:0] a);
    @(negedge clk);
    acc_addr = a; acc_valid = 1;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic err(input logic corr, input logic [5:0] syn, input logic [5:0] ham,
                     input logic pe, input logic pb);
    @(negedge clk);
    err_valid = 1; err_correctable = corr; err_syndrome = syn;
    err_hamming = ham; err_perr = pe; err_pbit = pb;
    @(negedge clk);
    err_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1;

    // R8: reset state
    rd(A_CTL, d);  check("R8 ctl", d, 16'hFFFF);
    rd(A_STAT, d); check("R8 stat", d, 16'hFFFF);
    rd(A_MEAR, d); check("R8 mear", d, 16'h0000);
    check("R8 wake/corr/test", {13'b0, wakeup, ecc_corr_en, ecc_test_mode}, 16'h0002);

    // R6: control readback and decoded outputs
    wr(A_CTL, 16'h0000);
    rd(A_CTL, d); check("R6 ctl zero", d, 16'h800F);
    check("R6 decode zero", {ecc_corr_en, ecc_test_mode, 7'b0, ecc_test_code}, {2'b01, 7'b0, 7'h7F});
    wr(A_CTL, 16'h1230);
    rd(A_CTL, d); check("R6 ctl 1230", d, 16'h923F);
    check("R6 decode 1230", {ecc_corr_en, ecc_test_mode, 7'b0, ecc_test_code}, {2'b01, 7'b0, 7'h5C});

    // R1: unmapped and non-strobed reads
    rd(16'hFE17, d); check("R1 unmapped", d, 16'h0000);
    @(negedge clk); bus_addr = A_CTL; #1 check("R1 no strobe", bus_rdata, 16'h0000);

    // R2: live address when nothing held
    access(18'h2_1234);
    rd(A_MEAR, d); check("R2 live", d, 16'h1234);

    // R4: a clean event captures nothing
    err(1'b0, 6'h00, 6'h3F, 1'b0, 1'b1);
    rd(A_STAT, d); check("R4 clean stat", d, 16'hFFFF);
    access(18'h2_1234);

    // R3: first error captured, low-true layout with bank from address
    wr(A_CTL, 16'hFFFF);
    err(1'b0, 6'h05, 6'h2A, 1'b1, 1'b0);
    rd(A_STAT, d); check("R3 stat", d, 16'h7A95);
    rd(A_MEAR, d); check("R2 latched", d, 16'h1234);

    // R4: second error and new access do not disturb
    access(18'h0_5678);
    err(1'b1, 6'h3F, 6'h00, 1'b0, 1'b1);
    rd(A_STAT, d); check("R4 stat frozen", d, 16'h7A95);
    rd(A_MEAR, d); check("R4 mear frozen", d, 16'h1234);

    // R5: status write clears and re-arms
    wr(A_STAT, 16'h1234);
    rd(A_STAT, d); check("R5 stat cleared", d, 16'hFFFF);
    rd(A_MEAR, d); check("R5 live again", d, 16'h5678);

    // R7: wakeup class table
    for (int i = 0; i < NV; i++) begin
      wr(A_CTL, VEC[i][16:1]);
      wr(A_STAT, 16'h0000);
      err(VEC[i][17], 6'h07, 6'h01, 1'b0, 1'b0);
      check($sformatf("R7 vec %0d", i), {15'b0, wakeup}, {15'b0, VEC[i][0]});
    end

    // R7: wakeup persists over further events until cleared
    err(1'b0, 6'h00, 6'h00, 1'b0, 1'b0);
    check("R7 persist", {15'b0, wakeup}, 16'h0001);
    wr(A_STAT, 16'h0000);
    check("R5 wake cleared", {15'b0, wakeup}, 16'h0000);

    // R5: clear and error in same cycle, clear wins
    wr(A_CTL, 16'hCFFF);
    @(negedge clk);
    bus_addr = A_STAT; bus_wr = 1; err_valid = 1; err_correctable = 0;
    err_syndrome = 6'h11; err_perr = 1;
    @(negedge clk);
    bus_wr = 0; err_valid = 0;
    check("R5 same-cycle wake", {15'b0, wakeup}, 16'h0000);
    rd(A_STAT, d); check("R5 same-cycle stat", d, 16'hFFFF);

    // R8: reset mid-run restores control
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(A_CTL, d); check("R8 ctl after reset", d, 16'hFFFF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule